// File: doc/BRIEF.md
# Alternating Valley Switching Selector

This block tells a quasi-resonant turn-on timing controller whether the next power switch turn-on should land on the first or on the second valley of the drain ringing. It watches the gate drive signal, measures how many timebase clocks each on-pulse lasts, and counts gate pulses with a free-running counter whose upper bit flips once every two pulses.

At each gate turn-off the block judges the operating point from the pulse that just ended: the feedback flag must be high (feedback above the trigger level) and the measured on-time must be shorter than a programmable limit. Both together indicate high input voltage. When they hold, the selection follows the pulse counter, so turn-ons go first, first, second, second and repeat, which hops the switching frequency to spread its spectrum. When they do not hold, the first valley is always chosen. The pulse counter keeps running whatever the condition, so entering or leaving alternation picks up the pattern wherever the counter stands.

Top module: `avs_valley_sel`

## Requirements
- R1: A synchronous active-high reset clears the pulse counter, the measured on-time (`ontime_meas` = 0), `alt_active` = 0 and `valley_second` = 0 (first valley).
- R2: The on-time is the number of rising clock edges at which `gate_on` is sampled high during one pulse; it appears on `ontime_meas` from the edge at which `gate_on` is first sampled low, and holds until the next turn-off.
- R3: The on-time count saturates at 2^ONTIME_W-1 and does not wrap for longer pulses.
- R4: The pulse counter advances by one on every gate rising edge, whatever the feedback flag or on-time; bit 1 of it is the pair bit.
- R5: Alternation is enabled (`alt_active` = 1) at a turn-off only when `fb_high` is 1 at that edge and the measured on-time is strictly less than SHORT_LIMIT (default 500 clocks, 4 µs at 125 MHz).
- R6: With alternation enabled, `valley_second` (1 = second valley, 0 = first valley) equals the pair bit after the pulse just ended, so successive pulses use first, first, second, second valleys and repeat, counted from the first pulse after reset.
- R7: With alternation not enabled at a turn-off, `valley_second` is 0.
- R8: `alt_active` and `valley_second` change only at the edge where a turn-off is seen and hold between turn-offs.
- R9: When alternation is entered or left, the next selection is taken from the current pair bit, not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on | input | 1 | Gate drive level, 1 while the switch is on |
| fb_high | input | 1 | Synchronous flag: feedback above the trigger level |
| valley_second | output | 1 | Valley choice for the next turn-on: 0 first, 1 second |
| alt_active | output | 1 | Alternation condition met at the last turn-off |
| ontime_meas | output | ONTIME_W | On-time of the last completed pulse, in clocks |

## Verification
Runs of short pulses with the feedback flag high show the first-first-second-second sequence and tell an every-pulse toggle or a shifted phase apart from the correct pair pattern. Pulses with the flag low, and pulses of exactly SHORT_LIMIT and SHORT_LIMIT-1 clocks, separate a correct AND of the two conditions and a strict comparison from an OR or an inclusive limit, while the counter is shown to keep counting underneath because the pattern resumes at the right phase. A pulse longer than the counter range exposes wrap-around, and a reset in the middle of a pattern checks that the phase restarts.

// File: rtl/avs_pkg.sv
package avs_pkg;

  // Valley choice encoding seen on valley_second
  typedef enum logic {
    VALLEY_FIRST  = 1'b0,
    VALLEY_SECOND = 1'b1
  } valley_e;

  // Width of the pulse counter; bit 1 is the pair bit
  localparam int PAIR_CNT_W = 2;

endpackage

// File: rtl/avs_ontime_meas.sv
module avs_ontime_meas #(
  parameter int ONTIME_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gate_on,
  output logic                gate_rise,
  output logic                gate_fall,
  output logic [ONTIME_W-1:0] ontime_cur,
  output logic [ONTIME_W-1:0] ontime_meas
);

  localparam logic [ONTIME_W-1:0] CNT_MAX = {ONTIME_W{1'b1}};
  localparam logic [ONTIME_W-1:0] CNT_ONE = {{(ONTIME_W-1){1'b0}}, 1'b1};

  logic                gate_q;
  logic [ONTIME_W-1:0] cnt_q;
  logic [ONTIME_W-1:0] meas_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_on;
  end

  always_comb begin
    gate_rise = gate_on & ~gate_q;
    gate_fall = ~gate_on & gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (gate_rise) begin
      cnt_q <= CNT_ONE;
    end else if (gate_on && gate_q && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            meas_q <= '0;
    else if (gate_fall) meas_q <= cnt_q;
  end

  assign ontime_cur  = cnt_q;
  assign ontime_meas = meas_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_q && gate_on && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R2
  meas_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_fall |=> $stable(meas_q));

endmodule

// File: rtl/avs_pair_count.sv
module avs_pair_count
  import avs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic gate_rise,
  output logic pair_bit
);

  logic [PAIR_CNT_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)            pc_q <= '0;
    else if (gate_rise) pc_q <= pc_q + 1'b1;
  end

  assign pair_bit = pc_q[1];

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    gate_rise |=> (pc_q == $past(pc_q) + 2'd1));

  // R4
  pc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_rise |=> $stable(pc_q));

endmodule

// File: rtl/avs_valley_dec.sv
module avs_valley_dec
  import avs_pkg::*;
#(
  parameter int ONTIME_W    = 12,
  parameter int SHORT_LIMIT = 500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gate_fall,
  input  logic                fb_high,
  input  logic [ONTIME_W-1:0] ontime_cur,
  input  logic                pair_bit,
  output logic                alt_active,
  output logic                valley_second
);

  localparam logic [ONTIME_W-1:0] LIMIT_V = ONTIME_W'(SHORT_LIMIT);

  logic    cond_now;
  logic    alt_q;
  valley_e sel_q;

  always_comb cond_now = fb_high && (ontime_cur < LIMIT_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_q <= 1'b0;
      sel_q <= VALLEY_FIRST;
    end else if (gate_fall) begin
      alt_q <= cond_now;
      sel_q <= (cond_now && pair_bit) ? VALLEY_SECOND : VALLEY_FIRST;
    end
  end

  assign alt_active    = alt_q;
  assign valley_second = sel_q;

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_fall |=> ($stable(sel_q) && $stable(alt_q)));

  // R7
  fb_low_first_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_fall && !fb_high) |=> (sel_q == VALLEY_FIRST));

  // R7
  sel_needs_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == VALLEY_SECOND) |-> alt_q);

endmodule

// File: rtl/avs_valley_sel.sv
module avs_valley_sel #(
  parameter int ONTIME_W    = 12,
  parameter int SHORT_LIMIT = 500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gate_on,
  input  logic                fb_high,
  output logic                valley_second,
  output logic                alt_active,
  output logic [ONTIME_W-1:0] ontime_meas
);

  logic                gate_rise;
  logic                gate_fall;
  logic [ONTIME_W-1:0] ontime_cur;
  logic                pair_bit;

  avs_ontime_meas #(.ONTIME_W(ONTIME_W)) u_meas (
    .clk        (clk),
    .rst        (rst),
    .gate_on    (gate_on),
    .gate_rise  (gate_rise),
    .gate_fall  (gate_fall),
    .ontime_cur (ontime_cur),
    .ontime_meas(ontime_meas)
  );

  avs_pair_count u_pair (
    .clk      (clk),
    .rst      (rst),
    .gate_rise(gate_rise),
    .pair_bit (pair_bit)
  );

  avs_valley_dec #(
    .ONTIME_W   (ONTIME_W),
    .SHORT_LIMIT(SHORT_LIMIT)
  ) u_dec (
    .clk          (clk),
    .rst          (rst),
    .gate_fall    (gate_fall),
    .fb_high      (fb_high),
    .ontime_cur   (ontime_cur),
    .pair_bit     (pair_bit),
    .alt_active   (alt_active),
    .valley_second(valley_second)
  );

  // R1
  rst_first_chk: assert property (@(posedge clk)
    rst |=> (!valley_second && !alt_active));

endmodule

// File: tb/sim_avs_valley_sel.sv
module sim_avs_valley_sel;

  localparam int W     = 12;
  localparam int LIMIT = 500;
  localparam int CMAX  = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         gate_on = 1'b0;
  logic         fb_high = 1'b0;
  logic         valley_second;
  logic         alt_active;
  logic [W-1:0] ontime_meas;

  int checks = 0;
  int errors = 0;
  int pc     = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  avs_valley_sel #(.ONTIME_W(W), .SHORT_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .gate_on(gate_on), .fb_high(fb_high),
    .valley_second(valley_second), .alt_active(alt_active),
    .ontime_meas(ontime_meas)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    gate_on = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pc = 0;
  endtask

  // One pulse of n clocks; checks outputs after the turn-off edge
  task automatic pulse(input int n, input bit f, input string req);
    int meas;
    bit en;
    @(negedge clk);
    gate_on = 1'b1;
    fb_high = f;
    repeat (n) @(negedge clk);
    gate_on = 1'b0;
    @(negedge clk);
    pc = (pc + 1) % 4;
    meas = (n > CMAX) ? CMAX : n;
    en = f && (meas < LIMIT);
    check({req, " ontime"}, int'(ontime_meas), meas);
    check({req, " alt"}, int'(alt_active), int'(en));
    check({req, " valley"}, int'(valley_second), (en && pc >= 2) ? 1 : 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 valley", int'(valley_second), 0);
    check("R1 alt", int'(alt_active), 0);
    check("R1 ontime", int'(ontime_meas), 0);
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 8; i++) pulse(20 + i, 1'b1, "R6");
  endtask

  task automatic t_fb_low();
    for (int i = 0; i < 3; i++) pulse(30, 1'b0, "R7");
    for (int i = 0; i < 3; i++) pulse(30, 1'b1, "R9");
  endtask

  task automatic t_limit();
    pulse(LIMIT, 1'b1, "R5 at limit");
    pulse(LIMIT - 1, 1'b1, "R5 below limit");
    pulse(LIMIT + 40, 1'b1, "R4 long");
    pulse(10, 1'b1, "R4 resume");
  endtask

  task automatic t_hold();
    pulse(12, 1'b1, "R2");
    fb_high = ~fb_high;
    repeat (5) @(negedge clk);
    check("R8 hold valley", int'(valley_second), (pc >= 2) ? 1 : 0);
    check("R8 hold alt", int'(alt_active), 1);
    check("R2 hold ontime", int'(ontime_meas), 12);
  endtask

  task automatic t_saturate();
    pulse(CMAX + 7, 1'b1, "R3");
  endtask

  task automatic t_mid_reset();
    pulse(15, 1'b1, "R6 pre");
    pulse(15, 1'b1, "R6 pre");
    do_reset();
    check("R1 mid valley", int'(valley_second), 0);
    for (int i = 0; i < 4; i++) pulse(15, 1'b1, "R1 phase");
  endtask

  initial begin
    t_reset();
    t_alternate();
    t_fb_low();
    t_limit();
    t_hold();
    t_saturate();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule